// File: doc/BRIEF.md
# PHY Management Register Slave

This block is the management side of an Ethernet physical-layer transceiver. A station manager drives a management clock and sends serial frames on a shared data line. The block watches that line and decodes each frame. When a frame carries the block's strapped 5-bit address, the block performs a 16-bit read or write on a small register bank. The bank holds control, status, two identifier words, the local advertisement, the link-partner ability, and a configuration word.

The control word drives the following plain output pins: software reset, loopback, power-down, auto-negotiation enable and auto-negotiation restart. Software reset and restart clear themselves only when the link logic returns a completion strobe. Status and link-partner data come in as plain inputs from the link logic.

The shared line is modelled as three signals: an input, an output value and an output enable. These combine at the pad. No stream of data passes through the block, so it has no valid/ready handshake and every pin is a plain level or strobe.

All inputs are synchronous to the management clock. Sampling happens on its rising edge, and the block launches read data from that same edge.

Top module: `mdio_phy_regs`

## Requirements
- R1: A frame whose 5-bit address field differs from `phy_addr` causes no drive of the line and no register change.
- R2: Frame layout:
  - Start is `0` then `1`, followed by a 2-bit opcode, the address, a 5-bit register number and a 2-bit turnaround.
  - Read opcode is `10`. The block leaves the line released for the first turnaround bit and drives `0` for the second.
  - It then drives 16 data bits, most significant bit first, and releases the line after the last one. The enable is held for 17 bit times in total.
- R3: Write opcode is `01`. After a `10` turnaround, 16 data bits MSB first are stored at the edge that samples the last bit. The outputs change from that edge on.
- R4: Preamble rule:
  - With preamble suppression off, a start pattern counts only after at least 32 consecutive ones; a shorter run makes the frame ignored.
  - Register 16 bit 0 turns suppression on (reset value 0). A frame then starts at the first `0`, with no preamble needed.
- R5: Software reset is register 0 bit 15.
  - Writing 1 sets `sw_reset`, and the bit reads 1 until a `reset_done` pulse.
  - That pulse clears the bit and returns register 0, register 4 and register 16 to their reset values. Register 0 reset value is `0x1000`, with enable on.
- R6: Restart is register 0 bit 9.
  - Writing 1 with bit 12 set raises `an_restart`, and the bit reads 1 until an `an_start_ack` pulse clears it.
  - Writing 0 to bit 9 does not clear a pending restart.
- R7: Auto-negotiation enable is register 0 bit 12. When a write leaves it at 0, `an_restart` is 0 and bit 9 reads 0.
- R8: Power-down is register 0 bit 11 and drives `power_down`. Reads and writes complete normally while it is set.
- R9: Loopback is register 0 bit 14 and drives `loopback`.
- R10: Identifier words:
  - Register 2 bits 15..0 hold identifier bits 3..18, taking parameter `OUI` index k-1 for identifier bit k, with bit 3 in position 15.
  - Register 3 holds identifier bits 19..24 in 15..10, the 6-bit model in 9..4 and the 4-bit revision in 3..0.
- R11: Read-only bits and unimplemented registers:
  - Writes to registers 1, 2, 3 and 5 and to unimplemented numbers are ignored, and unimplemented numbers read 0.
  - Register 4 keeps bits 4..0 at `00001` and bit 14 at 0. Its other bits are writable, and its reset value is `0x01E1`.
- R12: Register 1 reads as follows:
  - Bits 15..11 hold the `ABILITY` parameter.
  - Bit 6 reads 1, bit 5 is `an_complete`, bit 4 is `remote_fault`, bit 3 reads 1, bit 2 is `link_up` and bit 0 reads 1. All other bits read 0.
  - Register 5 reads `lp_ability`.
- R13: Frames with opcode `00` or `11` are skipped without any drive or register change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock from the station manager |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_addr | input | 5 | Strapped device address |
| mdio_in | input | 1 | Value seen on the shared data line |
| mdio_out | output | 1 | Value driven onto the data line |
| mdio_oe | output | 1 | Drive enable for the data line |
| sw_reset | output | 1 | Software reset request, held until done |
| loopback | output | 1 | Route receive data back to transmit |
| power_down | output | 1 | Power-down request |
| an_enable | output | 1 | Auto-negotiation enabled |
| an_restart | output | 1 | Auto-negotiation restart request |
| reset_done | input | 1 | One-cycle strobe: reset finished |
| an_start_ack | input | 1 | One-cycle strobe: restart accepted |
| link_up | input | 1 | Link status |
| an_complete | input | 1 | Auto-negotiation finished |
| remote_fault | input | 1 | Partner reports a fault |
| lp_ability | input | 16 | Link-partner ability word |

## Verification
The hardest case to reach is the interplay of the self-clearing bits with later writes. Examples are a pending restart that a write of 0 must not cancel, a restart request that a cleared enable must suppress, and a reset pulse that must wipe loopback, power-down and advertisement together. The stimulus reaches these by writing the control word, idling with the strobes low for several bit times, and then pulsing each strobe alone. After each step, pins are checked and the control word is read back.

A second hard case is the preamble counter. A short run of ones must be refused, while the same frame with suppression turned on must be taken with no preamble at all.

// File: rtl/mdio_phy_pkg.sv
package mdio_phy_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] RA_CTRL = 5'd0;
  localparam logic [ADDR_W-1:0] RA_STAT = 5'd1;
  localparam logic [ADDR_W-1:0] RA_ID_HI = 5'd2;
  localparam logic [ADDR_W-1:0] RA_ID_LO = 5'd3;
  localparam logic [ADDR_W-1:0] RA_ADV = 5'd4;
  localparam logic [ADDR_W-1:0] RA_PARTNER = 5'd5;
  localparam logic [ADDR_W-1:0] RA_CFG = 5'd16;

  localparam logic [1:0] OPC_RD = 2'b10;
  localparam logic [1:0] OPC_WR = 2'b01;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_HDR, ST_TURN, ST_SEND, ST_WTURN, ST_RECV, ST_SKIP
  } frame_st_e;
endpackage

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_phy_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              mdc,
  input  logic              rst_n,
  input  logic              mdio_in,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic              presup_en,
  input  logic [DATA_W-1:0] rd_data,
  output logic              mdio_out,
  output logic              mdio_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data
);
  localparam int HDR_BITS = 2 + 2 * ADDR_W;
  localparam int SKIP_BITS = 2 + DATA_W;
  localparam int PC_W = $clog2(PRE_LEN + 1);
  localparam int BC_W = $clog2(SKIP_BITS + 1);
  localparam logic [PC_W-1:0] PRE_FULL = PC_W'(PRE_LEN);

  frame_st_e st;
  logic [PC_W-1:0] pre_cnt;
  logic [BC_W-1:0] bit_cnt;
  logic [HDR_BITS-1:0] hdr_sh;
  logic [HDR_BITS-1:0] hdr_next;
  logic [DATA_W-1:0] dat_sh;
  logic [ADDR_W-1:0] ra_q;
  logic out_q, oe_q;
  logic addr_hit;

  assign hdr_next = {hdr_sh[HDR_BITS-2:0], mdio_in};
  assign addr_hit = (hdr_next[2*ADDR_W-1:ADDR_W] == phy_addr);
  assign wr_en = (st == ST_RECV) && (bit_cnt == BC_W'(DATA_W - 1));
  assign wr_data = {dat_sh[DATA_W-2:0], mdio_in};
  assign reg_addr = ra_q;
  assign mdio_out = out_q;
  assign mdio_oe = oe_q;

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      pre_cnt <= '0;
      bit_cnt <= '0;
      hdr_sh <= '0;
      dat_sh <= '0;
      ra_q <= '0;
      out_q <= 1'b0;
      oe_q <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (mdio_in) begin
            if (pre_cnt != PRE_FULL) pre_cnt <= pre_cnt + 1'b1;
          end else begin
            if ((pre_cnt == PRE_FULL) || presup_en) st <= ST_START;
            pre_cnt <= '0;
          end
        end
        ST_START: begin
          bit_cnt <= '0;
          st <= mdio_in ? ST_HDR : ST_IDLE;
        end
        ST_HDR: begin
          hdr_sh <= hdr_next;
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == BC_W'(HDR_BITS - 1)) begin
            bit_cnt <= '0;
            ra_q <= hdr_next[ADDR_W-1:0];
            if (addr_hit && hdr_next[HDR_BITS-1 -: 2] == OPC_RD) st <= ST_TURN;
            else if (addr_hit && hdr_next[HDR_BITS-1 -: 2] == OPC_WR) st <= ST_WTURN;
            else st <= ST_SKIP;
          end
        end
        ST_TURN: begin
          out_q <= 1'b0;
          oe_q <= 1'b1;
          dat_sh <= rd_data;
          bit_cnt <= '0;
          st <= ST_SEND;
        end
        ST_SEND: begin
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == BC_W'(DATA_W)) begin
            oe_q <= 1'b0;
            out_q <= 1'b0;
            st <= ST_IDLE;
          end else begin
            out_q <= dat_sh[DATA_W-1];
            dat_sh <= {dat_sh[DATA_W-2:0], 1'b0};
          end
        end
        ST_WTURN: begin
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == BC_W'(1)) begin
            bit_cnt <= '0;
            st <= ST_RECV;
          end
        end
        ST_RECV: begin
          dat_sh <= wr_data;
          bit_cnt <= bit_cnt + 1'b1;
          if (wr_en) st <= ST_IDLE;
        end
        ST_SKIP: begin
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == BC_W'(SKIP_BITS - 1)) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
  import mdio_phy_pkg::*;
#(
  parameter logic [23:0] OUI = 24'h5A3C96,
  parameter logic [5:0]  MODEL = 6'h0B,
  parameter logic [3:0]  REV = 4'h2,
  parameter logic [4:0]  ABILITY = 5'b11110,
  parameter logic [15:0] ADV_RESET = 16'h01E1,
  parameter logic [15:0] ADV_WMASK = 16'hBFE0,
  parameter logic [15:0] ADV_FIXED = 16'h0001
) (
  input  logic              mdc,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              reset_done,
  input  logic              an_start_ack,
  input  logic              link_up,
  input  logic              an_complete,
  input  logic              remote_fault,
  input  logic [DATA_W-1:0] lp_ability,
  output logic [DATA_W-1:0] rd_data,
  output logic              sw_reset,
  output logic              loopback,
  output logic              power_down,
  output logic              an_enable,
  output logic              an_restart,
  output logic              presup_en
);
  localparam int ID_HI_BITS = 16;
  localparam int ID_LO_BITS = 6;

  logic [DATA_W-1:0] id_hi, id_lo, ctrl_rd, stat_rd, adv_q;
  logic rst_q, loop_q, pd_q, ane_q, rsn_q, ps_q;

  for (genvar i = 0; i < ID_HI_BITS; i++) begin : g_id_hi
    assign id_hi[DATA_W-1-i] = OUI[2+i];
  end
  for (genvar j = 0; j < ID_LO_BITS; j++) begin : g_id_lo
    assign id_lo[DATA_W-1-j] = OUI[18+j];
  end
  assign id_lo[9:4] = MODEL;
  assign id_lo[3:0] = REV;

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 1'b0;
      loop_q <= 1'b0;
      pd_q <= 1'b0;
      ane_q <= 1'b1;
      rsn_q <= 1'b0;
      ps_q <= 1'b0;
      adv_q <= ADV_RESET;
    end else if (reset_done) begin
      rst_q <= 1'b0;
      loop_q <= 1'b0;
      pd_q <= 1'b0;
      ane_q <= 1'b1;
      rsn_q <= 1'b0;
      ps_q <= 1'b0;
      adv_q <= ADV_RESET;
    end else begin
      if (an_start_ack) rsn_q <= 1'b0;
      if (wr_en && reg_addr == RA_CTRL) begin
        rst_q <= rst_q | wr_data[15];
        loop_q <= wr_data[14];
        ane_q <= wr_data[12];
        pd_q <= wr_data[11];
        rsn_q <= wr_data[12] & (wr_data[9] | (rsn_q & ~an_start_ack));
      end
      if (wr_en && reg_addr == RA_ADV)
        adv_q <= (wr_data & ADV_WMASK) | ADV_FIXED;
      if (wr_en && reg_addr == RA_CFG)
        ps_q <= wr_data[0];
    end
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[15] = rst_q;
    ctrl_rd[14] = loop_q;
    ctrl_rd[12] = ane_q;
    ctrl_rd[11] = pd_q;
    ctrl_rd[9] = rsn_q;
    stat_rd = '0;
    stat_rd[15:11] = ABILITY;
    stat_rd[6] = 1'b1;
    stat_rd[5] = an_complete;
    stat_rd[4] = remote_fault;
    stat_rd[3] = 1'b1;
    stat_rd[2] = link_up;
    stat_rd[0] = 1'b1;
    unique case (reg_addr)
      RA_CTRL: rd_data = ctrl_rd;
      RA_STAT: rd_data = stat_rd;
      RA_ID_HI: rd_data = id_hi;
      RA_ID_LO: rd_data = id_lo;
      RA_ADV: rd_data = adv_q;
      RA_PARTNER: rd_data = lp_ability;
      RA_CFG: rd_data = {{(DATA_W-1){1'b0}}, ps_q};
      default: rd_data = '0;
    endcase
  end

  assign sw_reset = rst_q;
  assign loopback = loop_q;
  assign power_down = pd_q;
  assign an_enable = ane_q;
  assign an_restart = rsn_q;
  assign presup_en = ps_q;
endmodule

// File: rtl/mdio_phy_regs.sv
module mdio_phy_regs
  import mdio_phy_pkg::*;
#(
  parameter int          PRE_LEN = 32,
  parameter logic [23:0] OUI = 24'h5A3C96,
  parameter logic [5:0]  MODEL = 6'h0B,
  parameter logic [3:0]  REV = 4'h2,
  parameter logic [4:0]  ABILITY = 5'b11110
) (
  input  logic        mdc,
  input  logic        rst_n,
  input  logic [4:0]  phy_addr,
  input  logic        mdio_in,
  output logic        mdio_out,
  output logic        mdio_oe,
  output logic        sw_reset,
  output logic        loopback,
  output logic        power_down,
  output logic        an_enable,
  output logic        an_restart,
  input  logic        reset_done,
  input  logic        an_start_ack,
  input  logic        link_up,
  input  logic        an_complete,
  input  logic        remote_fault,
  input  logic [15:0] lp_ability
);
  logic [ADDR_W-1:0] reg_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic wr_en, presup_en;

  mdio_frame_engine #(.PRE_LEN(PRE_LEN)) u_frame (
    .mdc(mdc), .rst_n(rst_n), .mdio_in(mdio_in), .phy_addr(phy_addr),
    .presup_en(presup_en), .rd_data(rd_data), .mdio_out(mdio_out),
    .mdio_oe(mdio_oe), .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data)
  );

  mdio_reg_bank #(.OUI(OUI), .MODEL(MODEL), .REV(REV), .ABILITY(ABILITY)) u_bank (
    .mdc(mdc), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .reset_done(reset_done), .an_start_ack(an_start_ack),
    .link_up(link_up), .an_complete(an_complete), .remote_fault(remote_fault),
    .lp_ability(lp_ability), .rd_data(rd_data), .sw_reset(sw_reset),
    .loopback(loopback), .power_down(power_down), .an_enable(an_enable),
    .an_restart(an_restart), .presup_en(presup_en)
  );
endmodule

// File: rtl/mdio_phy_regs_chk.sv
module mdio_phy_regs_chk (
  input logic mdc,
  input logic rst_n,
  input logic mdio_oe,
  input logic mdio_out,
  input logic sw_reset,
  input logic loopback,
  input logic power_down,
  input logic an_enable,
  input logic an_restart,
  input logic reset_done,
  input logic an_start_ack
);
  logic [5:0] oe_cnt;

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) oe_cnt <= '0;
    else if (mdio_oe) oe_cnt <= oe_cnt + 1'b1;
    else oe_cnt <= '0;
  end

  a_r2_turn_low: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_out);

  a_r2_drive_len: assert property (@(posedge mdc) disable iff (!rst_n)
    $fell(mdio_oe) |-> oe_cnt == 6'd17);

  a_r5_reset_held: assert property (@(posedge mdc) disable iff (!rst_n)
    (sw_reset && !reset_done) |=> sw_reset);

  a_r5_reset_wipe: assert property (@(posedge mdc) disable iff (!rst_n)
    reset_done |=> (!sw_reset && !loopback && !power_down && an_enable && !an_restart));

  a_r6_restart_held: assert property (@(posedge mdc) disable iff (!rst_n)
    (an_restart && !an_start_ack && !reset_done) |=> (an_restart || !an_enable));

  a_r7_restart_needs_an: assert property (@(posedge mdc) disable iff (!rst_n)
    !an_enable |-> !an_restart);
endmodule

bind mdio_phy_regs mdio_phy_regs_chk u_chk (
  .mdc(mdc), .rst_n(rst_n), .mdio_oe(mdio_oe), .mdio_out(mdio_out),
  .sw_reset(sw_reset), .loopback(loopback), .power_down(power_down),
  .an_enable(an_enable), .an_restart(an_restart), .reset_done(reset_done),
  .an_start_ack(an_start_ack)
);

// File: tb/mdio_phy_regs_tb.sv
module mdio_phy_regs_tb;
  localparam logic [4:0]  MY_ADDR = 5'd9;
  localparam logic [23:0] OUI_V = 24'hC3A517;
  localparam logic [5:0]  MODEL_V = 6'h2D;
  localparam logic [3:0]  REV_V = 4'h6;
  localparam logic [4:0]  ABIL_V = 5'b10110;

  logic mdc = 1'b0;
  always #10 mdc = ~mdc;

  logic rst_n = 1'b0;
  logic mdio_in = 1'b1;
  logic mdio_out, mdio_oe;
  logic sw_reset, loopback, power_down, an_enable, an_restart;
  logic reset_done = 1'b0, an_start_ack = 1'b0;
  logic link_up = 1'b0, an_complete = 1'b0, remote_fault = 1'b0;
  logic [15:0] lp_ability = 16'h0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [15:0] val;
    string req;
  } exp_t;
  exp_t expq[$];

  mdio_phy_regs #(.PRE_LEN(32), .OUI(OUI_V), .MODEL(MODEL_V), .REV(REV_V), .ABILITY(ABIL_V)) u_dut (
    .mdc(mdc), .rst_n(rst_n), .phy_addr(MY_ADDR), .mdio_in(mdio_in),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .sw_reset(sw_reset),
    .loopback(loopback), .power_down(power_down), .an_enable(an_enable),
    .an_restart(an_restart), .reset_done(reset_done), .an_start_ack(an_start_ack),
    .link_up(link_up), .an_complete(an_complete), .remote_fault(remote_fault),
    .lp_ability(lp_ability)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pin(input logic act, input logic exp, input string req);
    check(act === exp, req, {15'd0, act}, {15'd0, exp});
  endtask

  task automatic send(input logic b);
    @(negedge mdc);
    mdio_in = b;
  endtask

  task automatic header(input int pre, input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra);
    repeat (pre) send(1'b1);
    send(1'b0); send(1'b1);
    for (int i = 1; i >= 0; i--) send(op[i]);
    for (int i = 4; i >= 0; i--) send(pa[i]);
    for (int i = 4; i >= 0; i--) send(ra[i]);
  endtask

  task automatic frame_wr(input int pre, input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d);
    header(pre, op, pa, ra);
    send(1'b1); send(1'b0);
    for (int i = 15; i >= 0; i--) send(d[i]);
    send(1'b1);
  endtask

  task automatic wr(input logic [4:0] ra, input logic [15:0] d);
    frame_wr(32, 2'b01, MY_ADDR, ra, d);
  endtask

  task automatic frame_rd(input int pre, input logic [4:0] pa, input logic [4:0] ra, input bit expect_it, input logic [15:0] exp, input string req);
    exp_t e;
    if (expect_it) begin
      e.val = exp;
      e.req = req;
      expq.push_back(e);
    end
    header(pre, 2'b10, pa, ra);
    repeat (20) send(1'b1);
  endtask

  task automatic rd(input logic [4:0] ra, input logic [15:0] exp, input string req);
    frame_rd(32, MY_ADDR, ra, 1'b1, exp, req);
  endtask

  function automatic logic [15:0] stat_exp(input logic lk, input logic anc, input logic rf);
    logic [15:0] v;
    v = '0;
    v[15:11] = ABIL_V;
    v[6] = 1'b1;
    v[5] = anc;
    v[4] = rf;
    v[3] = 1'b1;
    v[2] = lk;
    v[0] = 1'b1;
    return v;
  endfunction

  // Monitor: pops an expected item for every read the design drives (R2 timing).
  initial begin
    forever begin
      @(negedge mdc);
      if (mdio_oe === 1'b1) begin
        logic [15:0] v;
        exp_t e;
        check(mdio_out === 1'b0, "R2 turnaround zero", {15'd0, mdio_out}, 16'h0);
        v = '0;
        repeat (16) begin
          @(negedge mdc);
          v = {v[14:0], mdio_out};
        end
        @(negedge mdc);
        check(mdio_oe === 1'b0, "R2 release after data", {15'd0, mdio_oe}, 16'h0);
        if (expq.size() == 0) check(1'b0, "R1 unexpected drive", v, 16'h0);
        else begin
          e = expq.pop_front();
          check(v === e.val, e.req, v, e.val);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] idh, idl;
    repeat (4) @(negedge mdc);
    rst_n = 1'b1;
    @(negedge mdc);
    // reset state (R5 defaults)
    pin(mdio_oe, 1'b0, "R2 idle release");
    pin(sw_reset, 1'b0, "R5 reset value");
    pin(loopback, 1'b0, "R9 reset value");
    pin(power_down, 1'b0, "R8 reset value");
    pin(an_enable, 1'b1, "R5 enable reset value");
    pin(an_restart, 1'b0, "R6 reset value");

    // R10 identifiers
    idh = '0;
    idl = '0;
    for (int i = 0; i < 16; i++) idh[15-i] = OUI_V[2+i];
    for (int i = 0; i < 6; i++) idl[15-i] = OUI_V[18+i];
    idl[9:4] = MODEL_V;
    idl[3:0] = REV_V;
    rd(5'd2, idh, "R10 id high");
    rd(5'd3, idl, "R10 id low");

    // R12 status and partner
    link_up = 1'b1; remote_fault = 1'b1; lp_ability = 16'h45E1;
    rd(5'd1, stat_exp(1'b1, 1'b0, 1'b1), "R12 status a");
    rd(5'd5, 16'h45E1, "R12 partner");
    link_up = 1'b0; an_complete = 1'b1; remote_fault = 1'b0;
    rd(5'd1, stat_exp(1'b0, 1'b1, 1'b0), "R12 status b");

    // R11 read-only and unimplemented
    wr(5'd1, 16'h0000);
    rd(5'd1, stat_exp(1'b0, 1'b1, 1'b0), "R11 status write ignored");
    wr(5'd7, 16'hFFFF);
    rd(5'd7, 16'h0000, "R11 unimplemented reads zero");
    wr(5'd5, 16'h0000);
    rd(5'd5, 16'h45E1, "R11 partner write ignored");
    wr(5'd4, 16'hFFFF);
    rd(5'd4, 16'hBFE1, "R11 advertisement fixed bits");

    // R1 foreign address
    frame_rd(32, MY_ADDR ^ 5'd1, 5'd0, 1'b0, 16'h0, "R1");
    frame_wr(32, 2'b01, MY_ADDR ^ 5'd4, 5'd0, 16'h5000);
    pin(loopback, 1'b0, "R1 foreign write ignored");

    // R13 invalid opcodes
    frame_wr(32, 2'b11, MY_ADDR, 5'd0, 16'h5000);
    pin(loopback, 1'b0, "R13 opcode 11 ignored");
    frame_wr(32, 2'b00, MY_ADDR, 5'd0, 16'h5000);
    pin(loopback, 1'b0, "R13 opcode 00 ignored");

    // R9 / R3 loopback write
    wr(5'd0, 16'h5000);
    pin(loopback, 1'b1, "R9 loopback set");
    rd(5'd0, 16'h5000, "R3 control readback");

    // R8 power-down with access
    wr(5'd0, 16'h1800);
    pin(power_down, 1'b1, "R8 power-down set");
    pin(loopback, 1'b0, "R9 loopback cleared");
    rd(5'd0, 16'h1800, "R8 read while powered down");
    wr(5'd4, 16'h0DE1);
    rd(5'd4, 16'h0DE1, "R8 write while powered down");
    wr(5'd0, 16'h1000);
    pin(power_down, 1'b0, "R8 power-down cleared");

    // R6 restart held until ack
    wr(5'd0, 16'h1200);
    pin(an_restart, 1'b1, "R6 restart raised");
    rd(5'd0, 16'h1200, "R6 restart reads one");
    wr(5'd0, 16'h1000);
    pin(an_restart, 1'b1, "R6 writing zero keeps pending");
    repeat (6) @(negedge mdc);
    pin(an_restart, 1'b1, "R6 restart held");
    @(negedge mdc); an_start_ack = 1'b1;
    @(negedge mdc); an_start_ack = 1'b0;
    pin(an_restart, 1'b0, "R6 restart cleared by ack");
    rd(5'd0, 16'h1000, "R6 control after ack");

    // R7 restart with auto-negotiation off
    wr(5'd0, 16'h0200);
    pin(an_restart, 1'b0, "R7 restart suppressed");
    pin(an_enable, 1'b0, "R7 enable cleared");
    rd(5'd0, 16'h0000, "R7 restart reads zero");
    wr(5'd0, 16'h1200);
    wr(5'd0, 16'h0000);
    pin(an_restart, 1'b0, "R7 pending restart dropped");

    // R5 software reset
    wr(5'd0, 16'hC000);
    pin(sw_reset, 1'b1, "R5 reset raised");
    pin(loopback, 1'b1, "R5 loopback with reset");
    rd(5'd0, 16'hC000, "R5 reset reads one");
    pin(sw_reset, 1'b1, "R5 reset held");
    @(negedge mdc); reset_done = 1'b1;
    @(negedge mdc); reset_done = 1'b0;
    pin(sw_reset, 1'b0, "R5 reset cleared");
    pin(loopback, 1'b0, "R5 loopback restored");
    pin(an_enable, 1'b1, "R5 enable restored");
    rd(5'd0, 16'h1000, "R5 control restored");
    rd(5'd4, 16'h01E1, "R5 advertisement restored");

    // R4 preamble handling
    frame_wr(10, 2'b01, MY_ADDR, 5'd0, 16'h4000);
    pin(loopback, 1'b0, "R4 short preamble ignored");
    wr(5'd16, 16'h0001);
    rd(5'd16, 16'h0001, "R4 suppression bit");
    frame_wr(0, 2'b01, MY_ADDR, 5'd0, 16'h5000);
    pin(loopback, 1'b1, "R4 frame without preamble");
    frame_rd(0, MY_ADDR, 5'd0, 1'b1, 16'h5000, "R4 read without preamble");

    repeat (30) @(negedge mdc);
    check(expq.size() == 0, "R2 missing read data", 16'(expq.size()), 16'h0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule